// File: doc/BRIEF.md
# Programmable 3x3 Color Space Matrix

This block converts one 12-bit pixel per clock from one color space into another. It applies a fully programmable 3x3 matrix with a per-row offset. Each of the three output rows takes the red/Cr, green/Y and blue/Cb input components and weights them with three signed 13-bit coefficients in units of 1/4096. It then adds a signed offset, multiplies the total by a shared power-of-two gain, rounds once and clamps the result to the 12-bit output range.

The pixel stream is qualified by a valid flag. The enable, gain and all coefficients are captured with each pixel, so a configuration change never affects a pixel that is already in flight. When the matrix is disabled, the pixel passes through unchanged. The pass-through path has the same three-cycle delay as the arithmetic path, so downstream timing does not depend on the enable. The package supplies the usual power-up configuration as constants: row 0 = 0x0C52/0x0800/0x0000 with offset 0x19D7, row 1 = 0x1C54/0x0800/0x1E89, and gain code 1.

Top module: `csc_matrix`

## Requirements
- R1: Output res_r is produced by row 0 (row0_k0/k1/k2 weighting pix_r/pix_g/pix_b, offset row0_ofs), res_g by row 1, and res_b by row 2, using the same ordering.
- R2: Coefficients and offsets are 13-bit two's complement. The offset counts output LSBs. With gain factor G, each row yields floor(((k0*R + k1*G_in + k2*B + 4096*ofs)*G + 2048) / 4096), so rounding is half-up and happens once, after full-precision accumulation.
- R3: cfg_gain codes 0, 1 and 2 select gain factors 1, 2 and 4. Code 3 acts exactly like code 2.
- R4: A row result below 0 outputs 0, and a result above 4095 outputs 4095.
- R5: When cfg_en is 0 for a pixel, res_r/res_g/res_b equal that pixel's pix_r/pix_g/pix_b exactly, whatever the coefficients and gain are.
- R6: Every pixel appears exactly 3 clock cycles after it is sampled, with res_vld high, on both the matrix and bypass paths. res_vld is high only for sampled valid pixels. Back-to-back pixels are accepted every cycle.
- R7: The enable, gain, coefficients and offsets are sampled in the same cycle as the pixel. Changing them afterwards does not alter a result that is already in flight.
- R8: While reset (rst_n low, asynchronous) is active and until the first pixel emerges, res_vld and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_r | input | 12 | Red / Cr input component |
| pix_g | input | 12 | Green / Y input component |
| pix_b | input | 12 | Blue / Cb input component |
| pix_vld | input | 1 | Input pixel valid |
| cfg_en | input | 1 | 1 = apply matrix, 0 = pass-through |
| cfg_gain | input | 2 | Shared gain code |
| row0_k0 | input | 13 | Row 0 weight of pix_r |
| row0_k1 | input | 13 | Row 0 weight of pix_g |
| row0_k2 | input | 13 | Row 0 weight of pix_b |
| row0_ofs | input | 13 | Row 0 offset |
| row1_k0 | input | 13 | Row 1 weight of pix_r |
| row1_k1 | input | 13 | Row 1 weight of pix_g |
| row1_k2 | input | 13 | Row 1 weight of pix_b |
| row1_ofs | input | 13 | Row 1 offset |
| row2_k0 | input | 13 | Row 2 weight of pix_r |
| row2_k1 | input | 13 | Row 2 weight of pix_g |
| row2_k2 | input | 13 | Row 2 weight of pix_b |
| row2_ofs | input | 13 | Row 2 offset |
| res_r | output | 12 | Row 0 result |
| res_g | output | 12 | Row 1 result |
| res_b | output | 12 | Row 2 result |
| res_vld | output | 1 | Output valid, 3 cycles after pix_vld |

## Verification
The bench targets the rounding boundary, where a weighted sum of exactly half an LSB must round up. A design that truncates, or that rounds before adding the offset, would be one code low there. It drives full-scale positive and most-negative coefficients at the highest gain: a design that wraps instead of clamping returns small or huge wrong codes, and one that mishandles gain code 3 shows a factor-of-two error. It also toggles the enable and rewrites the coefficients in the cycle right after a pixel, so a design with an unequal bypass delay, or one that reads the configuration late, produces results in the wrong cycle or with the new weights.

// File: rtl/csc_pkg.sv
package csc_pkg;

  typedef enum logic [1:0] {
    GAIN_X1   = 2'd0,
    GAIN_X2   = 2'd1,
    GAIN_X4   = 2'd2,
    GAIN_X4_B = 2'd3
  } gain_e;

  // power-up configuration values
  localparam logic [1:0]  DEF_GAIN  = 2'd1;
  localparam logic [12:0] DEF_R0_K0 = 13'h0C52;
  localparam logic [12:0] DEF_R0_K1 = 13'h0800;
  localparam logic [12:0] DEF_R0_K2 = 13'h0000;
  localparam logic [12:0] DEF_R0_OF = 13'h19D7;
  localparam logic [12:0] DEF_R1_K0 = 13'h1C54;
  localparam logic [12:0] DEF_R1_K1 = 13'h0800;
  localparam logic [12:0] DEF_R1_K2 = 13'h1E89;

  // left-shift amount for a gain code; code 3 is clamped to x4
  function automatic logic [1:0] gain_shift(input logic [1:0] code);
    return (gain_e'(code) == GAIN_X4_B) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/csc_delay.sv
module csc_delay #(
  parameter int W = 8,
  parameter int D = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [D];

  generate
    for (genvar i = 0; i < D; i++) begin : g_stg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stg[i] <= '0;
        else if (i == 0) stg[i] <= din;
        else             stg[i] <= stg[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign dout = stg[D-1];

endmodule

// File: rtl/csc_row.sv
module csc_row #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PIX_W-1:0]         in0,
  input  logic [PIX_W-1:0]         in1,
  input  logic [PIX_W-1:0]         in2,
  input  logic signed [COEF_W-1:0] k0,
  input  logic signed [COEF_W-1:0] k1,
  input  logic signed [COEF_W-1:0] k2,
  input  logic signed [COEF_W-1:0] ofs,
  input  logic [1:0]               shamt,
  output logic [PIX_W-1:0]         res
);

  localparam int PROD_W  = COEF_W + PIX_W + 1;
  localparam int ACC_W   = PROD_W + 3;
  localparam int SCL_W   = ACC_W + 3;
  localparam int HALF    = 1 << (FRAC_W - 1);
  localparam int PIX_MAX = (1 << PIX_W) - 1;

  // stage 1: products, offset and shift captured with the pixel
  logic signed [PROD_W-1:0] p0_d, p1_d, p2_d, p0_q, p1_q, p2_q;
  logic signed [COEF_W-1:0] ofs_q;
  logic [1:0]               sh1_q, sh2_q;
  logic signed [ACC_W-1:0]  acc_q;

  assign p0_d = PROD_W'(k0) * PROD_W'($signed({1'b0, in0}));
  assign p1_d = PROD_W'(k1) * PROD_W'($signed({1'b0, in1}));
  assign p2_d = PROD_W'(k2) * PROD_W'($signed({1'b0, in2}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_q <= '0; p1_q <= '0; p2_q <= '0;
      ofs_q <= '0; sh1_q <= '0;
    end else begin
      p0_q <= p0_d; p1_q <= p1_d; p2_q <= p2_d;
      ofs_q <= ofs; sh1_q <= shamt;
    end
  end

  // stage 2: full-precision sum with offset aligned to the fraction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; sh2_q <= '0;
    end else begin
      acc_q <= ACC_W'(p0_q) + ACC_W'(p1_q) + ACC_W'(p2_q)
             + (ACC_W'(ofs_q) <<< FRAC_W);
      sh2_q <= sh1_q;
    end
  end

  // stage 3: gain, single rounding, clamp
  logic signed [SCL_W-1:0] scaled, whole;
  logic acc_under, acc_over;

  assign scaled    = (SCL_W'(acc_q) <<< sh2_q) + SCL_W'(HALF);
  assign whole     = scaled >>> FRAC_W;
  assign acc_under = (scaled < 0);
  assign acc_over  = !acc_under && (whole > SCL_W'(PIX_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res <= '0;
    else if (acc_under) res <= '0;
    else if (acc_over)  res <= '1;
    else                res <= whole[PIX_W-1:0];
  end

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    acc_under |=> (res == '0)); // R4
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc_over |=> (res == {PIX_W{1'b1}})); // R4

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix #(
  parameter int PIX_W  = 12,
  parameter int COEF_W = 13,
  parameter int FRAC_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIX_W-1:0]  pix_r,
  input  logic [PIX_W-1:0]  pix_g,
  input  logic [PIX_W-1:0]  pix_b,
  input  logic              pix_vld,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_gain,
  input  logic [COEF_W-1:0] row0_k0,
  input  logic [COEF_W-1:0] row0_k1,
  input  logic [COEF_W-1:0] row0_k2,
  input  logic [COEF_W-1:0] row0_ofs,
  input  logic [COEF_W-1:0] row1_k0,
  input  logic [COEF_W-1:0] row1_k1,
  input  logic [COEF_W-1:0] row1_k2,
  input  logic [COEF_W-1:0] row1_ofs,
  input  logic [COEF_W-1:0] row2_k0,
  input  logic [COEF_W-1:0] row2_k1,
  input  logic [COEF_W-1:0] row2_k2,
  input  logic [COEF_W-1:0] row2_ofs,
  output logic [PIX_W-1:0]  res_r,
  output logic [PIX_W-1:0]  res_g,
  output logic [PIX_W-1:0]  res_b,
  output logic              res_vld
);

  localparam int ROWS  = 3;
  localparam int LAT   = 3;             // stages inside csc_row
  localparam int SIDEW = 3*PIX_W + 2;   // valid, enable, bypass pixel

  logic signed [COEF_W-1:0] kmat [ROWS][3];
  logic signed [COEF_W-1:0] koff [ROWS];
  logic [PIX_W-1:0]         row_res [ROWS];
  logic [1:0]               gsh;

  assign kmat[0][0] = $signed(row0_k0); assign kmat[0][1] = $signed(row0_k1);
  assign kmat[0][2] = $signed(row0_k2); assign koff[0]    = $signed(row0_ofs);
  assign kmat[1][0] = $signed(row1_k0); assign kmat[1][1] = $signed(row1_k1);
  assign kmat[1][2] = $signed(row1_k2); assign koff[1]    = $signed(row1_ofs);
  assign kmat[2][0] = $signed(row2_k0); assign kmat[2][1] = $signed(row2_k1);
  assign kmat[2][2] = $signed(row2_k2); assign koff[2]    = $signed(row2_ofs);

  assign gsh = csc_pkg::gain_shift(cfg_gain);

  generate
    for (genvar i = 0; i < ROWS; i++) begin : g_row
      csc_row #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_row (
        .clk   (clk),
        .rst_n (rst_n),
        .in0   (pix_r),
        .in1   (pix_g),
        .in2   (pix_b),
        .k0    (kmat[i][0]),
        .k1    (kmat[i][1]),
        .k2    (kmat[i][2]),
        .ofs   (koff[i]),
        .shamt (gsh),
        .res   (row_res[i])
      );
    end
  endgenerate

  // valid, enable and raw pixel travel alongside the arithmetic
  logic [SIDEW-1:0] side_d, side_q;
  logic             en_d;
  logic [PIX_W-1:0] byp_r, byp_g, byp_b;

  assign side_d = {pix_vld, cfg_en, pix_r, pix_g, pix_b};

  csc_delay #(.W(SIDEW), .D(LAT)) u_side (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (side_d),
    .dout  (side_q)
  );

  assign {res_vld, en_d, byp_r, byp_g, byp_b} = side_q;

  assign res_r = en_d ? row_res[0] : byp_r;
  assign res_g = en_d ? row_res[1] : byp_g;
  assign res_b = en_d ? row_res[2] : byp_b;

  // cycles since reset, saturating, used to bound $past windows
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (res_vld == $past(pix_vld, 3))); // R6
  AST_BYPASS_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q == 2'd3) && !$past(cfg_en, 3)) |->
      (res_r == $past(pix_r, 3) && res_g == $past(pix_g, 3)
       && res_b == $past(pix_b, 3))); // R5
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 2'd3) |-> !res_vld); // R8

endmodule

// File: tb/csc_matrix_tb.sv
module csc_matrix_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0;
  logic        pix_vld = 1'b0, cfg_en = 1'b0;
  logic [1:0]  cfg_gain = 2'd0;
  logic signed [12:0] cf [3][4];
  logic [11:0] res_r, res_g, res_b;
  logic        res_vld;

  csc_matrix u_dut (
    .clk(clk), .rst_n(rst_n),
    .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b), .pix_vld(pix_vld),
    .cfg_en(cfg_en), .cfg_gain(cfg_gain),
    .row0_k0(cf[0][0]), .row0_k1(cf[0][1]), .row0_k2(cf[0][2]), .row0_ofs(cf[0][3]),
    .row1_k0(cf[1][0]), .row1_k1(cf[1][1]), .row1_k2(cf[1][2]), .row1_ofs(cf[1][3]),
    .row2_k0(cf[2][0]), .row2_k1(cf[2][1]), .row2_k2(cf[2][2]), .row2_ofs(cf[2][3]),
    .res_r(res_r), .res_g(res_g), .res_b(res_b), .res_vld(res_vld)
  );

  typedef struct {
    logic [11:0] r, g, b;
    int          cyc;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // independent reference: integer math, then round and clamp
  function automatic logic [11:0] model(input int row, input logic [11:0] r,
                                        input logic [11:0] g, input logic [11:0] b);
    longint v;
    int gain;
    gain = (cfg_gain == 2'd0) ? 1 : (cfg_gain == 2'd1) ? 2 : 4;
    v = longint'(cf[row][0]) * longint'(r) + longint'(cf[row][1]) * longint'(g)
      + longint'(cf[row][2]) * longint'(b) + longint'(cf[row][3]) * 4096;
    v = v * gain + 2048;
    if (v < 0) return 12'd0;
    v = v / 4096;
    if (v > 4095) return 12'hFFF;
    return v[11:0];
  endfunction

  task automatic send(input logic [11:0] r, input logic [11:0] g,
                      input logic [11:0] b, input logic en, input string tag);
    exp_t e;
    pix_r = r; pix_g = g; pix_b = b; cfg_en = en; pix_vld = 1'b1;
    if (en) begin
      e.r = model(0, r, g, b); e.g = model(1, r, g, b); e.b = model(2, r, g, b);
    end else begin
      e.r = r; e.g = g; e.b = b;
    end
    e.cyc = cyc; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    pix_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic set_row(input int row, input logic [12:0] k0, input logic [12:0] k1,
                         input logic [12:0] k2, input logic [12:0] of);
    cf[row][0] = k0; cf[row][1] = k1; cf[row][2] = k2; cf[row][3] = of;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && res_vld) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R6: unexpected res_vld, actual 1 expected 0");
      end else begin
        exp_t e;
        e = q.pop_front();
        if (res_r !== e.r || res_g !== e.g || res_b !== e.b) begin
          errors++;
          $display("FAIL %s: actual %h/%h/%h expected %h/%h/%h",
                   e.tag, res_r, res_g, res_b, e.r, e.g, e.b);
        end
        if (cyc - e.cyc != 3) begin
          errors++;
          $display("FAIL R6: latency actual %0d expected 3", cyc - e.cyc);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    set_row(0, csc_pkg::DEF_R0_K0, csc_pkg::DEF_R0_K1, csc_pkg::DEF_R0_K2, csc_pkg::DEF_R0_OF);
    set_row(1, csc_pkg::DEF_R1_K0, csc_pkg::DEF_R1_K1, csc_pkg::DEF_R1_K2, 13'h0000);
    set_row(2, 13'h0400, 13'h0200, 13'h0C00, 13'h0010);
    cfg_gain = csc_pkg::DEF_GAIN;

    // R8: outputs quiet in reset and just after release
    repeat (3) @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_r !== 12'd0 || res_g !== 12'd0 || res_b !== 12'd0) begin
      errors++;
      $display("FAIL R8: in reset actual %b/%h/%h/%h expected 0/0/0/0",
               res_vld, res_r, res_g, res_b);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_vld !== 1'b0 || res_r !== 12'd0) begin
      errors++;
      $display("FAIL R8: after reset actual %b/%h expected 0/0", res_vld, res_r);
    end

    // R1, R2: power-up configuration on assorted pixels, back to back (R6)
    send(12'd0, 12'd0, 12'd0, 1'b1, "R1");
    send(12'hFFF, 12'hFFF, 12'hFFF, 1'b1, "R1");
    send(12'd2048, 12'd1024, 12'd512, 1'b1, "R2");
    send(12'd100, 12'd3000, 12'd50, 1'b1, "R2");
    idle(2);

    // R1: each row picks out one distinct input
    cfg_gain = 2'd0;
    set_row(0, 13'h0000, 13'h0000, 13'h0FFF, 13'h0001);
    set_row(1, 13'h0FFF, 13'h0000, 13'h0000, 13'h0000);
    set_row(2, 13'h0000, 13'h0FFF, 13'h0000, 13'h0000);
    send(12'd300, 12'd1700, 12'd2900, 1'b1, "R1");

    // R2: half-LSB rounding boundary, negative offset
    set_row(0, 13'h0001, 13'h0000, 13'h0000, 13'h0000);
    set_row(1, 13'h0001, 13'h0000, 13'h0000, 13'h1FFF);
    set_row(2, 13'h1FFF, 13'h0000, 13'h0000, 13'h0005);
    send(12'd2048, 12'd0, 12'd0, 1'b1, "R2");
    send(12'd2047, 12'd0, 12'd0, 1'b1, "R2");
    send(12'd4095, 12'd7, 12'd9, 1'b1, "R2");
    idle(1);

    // R3: gain sweep including code 3
    set_row(0, 13'h0800, 13'h0000, 13'h0000, 13'h0000);
    set_row(1, 13'h0000, 13'h0400, 13'h0000, 13'h0003);
    set_row(2, 13'h0000, 13'h0000, 13'h0200, 13'h1FF0);
    for (int m = 0; m < 4; m++) begin
      cfg_gain = 2'(m);
      send(12'd1000, 12'd1500, 12'd3000, 1'b1, "R3");
    end
    idle(1);

    // R4: clamp high and low at maximum gain
    cfg_gain = 2'd2;
    set_row(0, 13'h0FFF, 13'h0FFF, 13'h0FFF, 13'h0FFF);
    set_row(1, 13'h1000, 13'h1000, 13'h1000, 13'h1000);
    set_row(2, 13'h0FFF, 13'h1000, 13'h0000, 13'h0000);
    send(12'hFFF, 12'hFFF, 12'hFFF, 1'b1, "R4");
    send(12'd1, 12'd1, 12'd1, 1'b1, "R4");
    send(12'd4000, 12'd10, 12'd0, 1'b1, "R4");
    idle(1);

    // R5: bypass ignores coefficients and gain, interleaved with matrix (R6)
    send(12'h123, 12'hABC, 12'hFFF, 1'b0, "R5");
    send(12'h000, 12'h800, 12'h7FF, 1'b1, "R6");
    send(12'h555, 12'hAAA, 12'h001, 1'b0, "R5");
    send(12'hFFF, 12'h000, 12'h3C3, 1'b0, "R5");
    idle(2);

    // R7: configuration rewritten in the cycle after the pixel
    cfg_gain = 2'd1;
    set_row(0, 13'h0400, 13'h0000, 13'h0000, 13'h0000);
    set_row(1, 13'h0000, 13'h0400, 13'h0000, 13'h0000);
    set_row(2, 13'h0000, 13'h0000, 13'h0400, 13'h0000);
    send(12'd800, 12'd1200, 12'd2000, 1'b1, "R7");
    cfg_gain = 2'd0; cfg_en = 1'b0;
    set_row(0, 13'h0FFF, 13'h0FFF, 13'h0FFF, 13'h0FFF);
    set_row(1, 13'h1000, 13'h0000, 13'h0000, 13'h1000);
    set_row(2, 13'h0000, 13'h0000, 13'h0000, 13'h0000);
    idle(6);

    // R6: nothing left outstanding
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6: pending results actual %0d expected 0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule